// File: doc/BRIEF.md
# Two-Operand ALU with Zero and Carry Flags

This block is the execute stage of a small register machine. Each request carries a 3-bit operation code, two register-index fields and the two 32-bit operand values already read from those registers. The block works out the result, decides whether and where that result is written back, and keeps the flags word. Bit 0 of the flags word is the zero flag and bit 1 is the carry flag.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. The result of that request appears in the output register on the same edge. The output register keeps its contents unchanged until `res_ready` is high together with `res_valid`. `in_ready` equals `!res_valid || res_ready`, so a single output slot is the only buffering. A transfer with a legal code updates the flags word on its accepting edge, so `flags` always matches the result currently on offer. The register file stays outside the block. It uses `res_we`, `res_dest` and `res_data`.

Top module: `alu_flagged`

## Requirements
- R1: Operation code 0 (add) produces A+B modulo 2^32. Carry is set to the unsigned carry out of bit 31.
- R2: Operation codes 1 (subtract) and 4 (compare) produce A−B modulo 2^32. Carry is set exactly when B > A as unsigned numbers.
- R3: Operation code 2 (shift left) produces A shifted left by one bit, with a zero entering bit 0. Carry takes A[31].
- R4: Operation code 3 (shift right) produces A shifted right by one bit, with a zero entering bit 31. Carry takes A[0].
- R5: After a legal operation, flags bit 0 is 1 exactly when the 32-bit result is zero. Flags bits 31..2 never change from their reset value of 0.
- R6: Compare updates the flags and presents its result with `res_we` = 0.
- R7: For codes 0, 1 and 4, `res_dest` is `fld_b`. For codes 2 and 3, `res_dest` is `fld_a`. Every legal code except compare gives `res_we` = 1.
- R8: Codes 5, 6 and 7 give `res_err` = 1, `res_we` = 0, `res_data` = 0 and `res_dest` = 0, and they leave the flags word unchanged.
- R9: A result stays stable while `res_valid` is high and `res_ready` is low, and `in_ready` is low during that time. Results come out in request order, one for each accepted request.
- R10: After reset, `res_valid` is 0, `flags` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request is valid |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 3 | Operation code |
| fld_a | input | 8 | Index of register A |
| fld_b | input | 8 | Index of register B |
| opnd_a | input | 32 | Value of register A |
| opnd_b | input | 32 | Value of register B |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Result value |
| res_we | output | 1 | Result must be written to `res_dest` |
| res_dest | output | 8 | Destination register index |
| res_err | output | 1 | Request carried an illegal code |
| flags | output | 32 | Flags word (bit 0 zero, bit 1 carry) |

## Verification
The assertions check on every cycle that a stalled result holds steady and that the upper flag bits never move. They also check that the zero flag agrees with any legal result on offer, that compare never asserts the write, that an illegal code leaves the flags alone, and that shifts load the carry from the bit shifted out. Only the bench scenarios can show the actual arithmetic values and the borrow and wrap boundaries (all-ones plus one, equal operands, a smaller minuend). The same applies to destination selection for each code and to in-order delivery when the consumer stalls at irregular times.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SHL = 3'd2,
    OP_SHR = 3'd3,
    OP_CMP = 3'd4
  } alu_op_e;

  localparam int OP_W = 3;
endpackage

// File: rtl/alu_core.sv
module alu_core #(
  parameter int DATA_W = 32
) (
  input  logic [alu_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic [DATA_W-1:0]        result,
  output logic                     carry,
  output logic                     legal
);
  import alu_pkg::*;

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] diff_w;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    diff_w = {1'b0, a} - {1'b0, b};
    result = '0;
    carry  = 1'b0;
    legal  = 1'b1;
    case (op)
      OP_ADD: begin
        result = sum_w[DATA_W-1:0];
        carry  = sum_w[DATA_W];
      end
      OP_SUB, OP_CMP: begin
        result = diff_w[DATA_W-1:0];
        carry  = diff_w[DATA_W];
      end
      OP_SHL: begin
        result = {a[DATA_W-2:0], 1'b0};
        carry  = a[DATA_W-1];
      end
      OP_SHR: begin
        result = {1'b0, a[DATA_W-1:1]};
        carry  = a[0];
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_wb.sv
module alu_wb #(
  parameter int IDX_W = 8
) (
  input  logic [alu_pkg::OP_W-1:0] op,
  input  logic [IDX_W-1:0]         fld_a,
  input  logic [IDX_W-1:0]         fld_b,
  output logic [IDX_W-1:0]         dest,
  output logic                     we
);
  import alu_pkg::*;

  always_comb begin
    dest = '0;
    we   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin dest = fld_b; we = 1'b1; end
      OP_CMP:         begin dest = fld_b; we = 1'b0; end
      OP_SHL, OP_SHR: begin dest = fld_a; we = 1'b1; end
      default:        begin dest = '0;    we = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int FLAG_W    = 32,
  parameter int ZERO_BIT  = 0,
  parameter int CARRY_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              zero_in,
  input  logic              carry_in,
  output logic [FLAG_W-1:0] flags_q
);
  localparam logic [FLAG_W-1:0] OWN_MASK =
    (FLAG_W'(1) << ZERO_BIT) | (FLAG_W'(1) << CARRY_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd) begin
      flags_q[ZERO_BIT]  <= zero_in;
      flags_q[CARRY_BIT] <= carry_in;
    end
  end

  p_upper_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(flags_q & ~OWN_MASK));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 8,
  parameter int FLAG_W    = 32,
  parameter int ZERO_BIT  = 0,
  parameter int CARRY_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [IDX_W-1:0]  fld_a,
  input  logic [IDX_W-1:0]  fld_b,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_dest,
  output logic              res_err,
  output logic [FLAG_W-1:0] flags
);
  import alu_pkg::*;

  logic [DATA_W-1:0] core_res;
  logic              core_carry;
  logic              core_legal;
  logic [IDX_W-1:0]  wb_dest;
  logic              wb_we;
  logic              accept;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op(in_op), .a(opnd_a), .b(opnd_b),
    .result(core_res), .carry(core_carry), .legal(core_legal)
  );

  alu_wb #(.IDX_W(IDX_W)) u_wb (
    .op(in_op), .fld_a(fld_a), .fld_b(fld_b),
    .dest(wb_dest), .we(wb_we)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  alu_flags #(.FLAG_W(FLAG_W), .ZERO_BIT(ZERO_BIT), .CARRY_BIT(CARRY_BIT)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd(accept && core_legal),
    .zero_in(core_res == '0),
    .carry_in(core_carry),
    .flags_q(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_we    <= 1'b0;
      res_dest  <= '0;
      res_err   <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= core_legal ? core_res : '0;
      res_we    <= wb_we && core_legal;
      res_dest  <= core_legal ? wb_dest : '0;
      res_err   <= !core_legal;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
      $stable(res_we) && $stable(res_dest) && $stable(res_err)));

  p_zero_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (flags[ZERO_BIT] == (res_data == '0)));

  p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd4) |=> (res_valid && !res_we));

  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op > 3'd4) |=> (res_err && !res_we));

  p_shl_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd2) |=> (flags[CARRY_BIT] == $past(opnd_a[DATA_W-1])));

  p_shr_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd3) |=> (flags[CARRY_BIT] == $past(opnd_a[0])));
endmodule

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, res_valid, res_ready, res_we, res_err;
  logic [2:0]  in_op;
  logic [7:0]  fld_a, fld_b, res_dest;
  logic [31:0] opnd_a, opnd_b, res_data, flags;

  alu_flagged dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .fld_a(fld_a), .fld_b(fld_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_we(res_we), .res_dest(res_dest), .res_err(res_err), .flags(flags)
  );

  typedef struct {
    logic [31:0] data;
    logic        we;
    logic [7:0]  dest;
    logic        err;
    logic [31:0] flg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, fails = 0, pops = 0;
  logic [31:0] mflags = '0;
  bit          stall_mode = 0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(logic [2:0] op, logic [7:0] fa, logic [7:0] fb,
                      logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    logic [32:0] w;
    e.tag = tag; e.err = 0; e.we = 1; e.dest = fb; e.data = 0;
    case (op)
      3'd0: begin w = {1'b0,a} + {1'b0,b}; e.data = w[31:0]; mflags[1] = w[32]; end
      3'd1, 3'd4: begin e.data = a - b; mflags[1] = (b > a); e.we = (op == 3'd1); end
      3'd2: begin e.data = a << 1; mflags[1] = a[31]; e.dest = fa; end
      3'd3: begin e.data = a >> 1; mflags[1] = a[0]; e.dest = fa; end
      default: begin e.err = 1; e.we = 0; e.dest = 0; end
    endcase
    if (!e.err) mflags[0] = (e.data == 0);
    e.flg = mflags;
    in_op = op; fld_a = fa; fld_b = fb; opnd_a = a; opnd_b = b; in_valid = 1;
    while (!in_ready) @(negedge clk);
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    res_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && res_valid && !res_ready)
      chk(in_ready == 0, "R9", "in_ready during stall", {31'b0, in_ready}, 32'd0);
    if (rst_n && res_valid && res_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R9", "unexpected result", res_data, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        pops++;
        chk(res_data == e.data, e.tag, "data", res_data, e.data);
        chk(res_we == e.we, e.tag, "we", {31'b0, res_we}, {31'b0, e.we});
        chk(res_dest == e.dest, e.tag, "dest", {24'b0, res_dest}, {24'b0, e.dest});
        chk(res_err == e.err, e.tag, "err", {31'b0, res_err}, {31'b0, e.err});
        chk(flags == e.flg, e.tag, "flags", flags, e.flg);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_op = 0; fld_a = 0; fld_b = 0; opnd_a = 0; opnd_b = 0;
    res_ready = 1;
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R10", "res_valid in reset", {31'b0, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0, "R10", "res_valid after reset", {31'b0, res_valid}, 0);
    chk(flags == 0, "R10", "flags after reset", flags, 0);
    chk(in_ready == 1, "R10", "in_ready after reset", {31'b0, in_ready}, 1);

    send(3'd0, 8'd1, 8'd2, 32'd5, 32'd7, "R1 add");
    send(3'd0, 8'd3, 8'd4, 32'hFFFF_FFFF, 32'd1, "R1 R5 add wrap");
    send(3'd1, 8'd5, 8'd6, 32'd10, 32'd3, "R2 sub");
    send(3'd1, 8'd7, 8'd8, 32'd3, 32'd10, "R2 sub borrow");
    send(3'd1, 8'd9, 8'd10, 32'd5, 32'd5, "R2 R5 sub equal");
    send(3'd2, 8'd11, 8'd12, 32'h8000_0001, 32'd0, "R3 R7 shl");
    send(3'd2, 8'd13, 8'd14, 32'd0, 32'd9, "R3 R5 shl zero");
    send(3'd3, 8'd15, 8'd16, 32'd3, 32'd0, "R4 R7 shr");
    send(3'd3, 8'd17, 8'd18, 32'd1, 32'd0, "R4 R5 shr to zero");
    send(3'd4, 8'd19, 8'd20, 32'd2, 32'd9, "R6 R7 cmp");
    send(3'd4, 8'd21, 8'd22, 32'd9, 32'd9, "R6 cmp equal");
    send(3'd5, 8'd23, 8'd24, 32'd1, 32'd2, "R8 code5");
    send(3'd6, 8'd25, 8'd26, 32'd0, 32'd0, "R8 code6");
    send(3'd7, 8'd27, 8'd28, 32'd4, 32'd4, "R8 code7");

    stall_mode = 1;
    for (int i = 0; i < 40; i++)
      send(3'(i % 8), 8'(i), 8'(i + 100), 32'(i * 32'h1357_9BDF), 32'(i * 7), "R9 stall");
    stall_mode = 0;

    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    chk(sb.size() == 0, "R9", "results outstanding", sb.size(), 0);
    chk(pops == 54, "R9", "result count", pops, 54);
    finish_run();
  end
endmodule